// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This unit is the interrupt register group of a serial peripheral controller. It takes seven interrupt sources from the FIFOs and the shift engine and keeps a 7-bit status word. It also keeps a 7-bit mask and drives one registered interrupt line. Two of the sources are live FIFO conditions: receive data present on bit 4 and transmit space free on bit 2. The status word only mirrors these two. The other five sources are event pulses. Each one sets a sticky status bit, and software clears that bit by writing a one to it.

Software never writes the mask directly. A write to the set-command register turns on the mask bits written as one. A write to the clear-command register turns off the mask bits written as one. The mask itself can be read at its own read-only offset. Bits written as zero in either command register leave the mask unchanged, so several drivers can share it without a read-modify-write.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status word, the mask and `irq_o` are all zero.
- R2: An event source (bits 0, 1, 3, 5 and 6) that is high on a clock edge sets its status bit after that edge. The bit stays set after the source goes low.
- R3: A write to offset 0x04 clears each latched event bit whose data bit is 1. Event bits written as 0 are unchanged.
- R4: If a clear write and a source pulse reach the same event bit on the same edge, the bit ends set.
- R5: Status bits 4 (receive data present) and 2 (transmit space free) equal the source level sampled on the previous edge. A clear write to offset 0x04 has no effect on them.
- R6: A write to offset 0x08 sets each mask bit whose data bit is 1. Mask bits written as 0 are unchanged.
- R7: A write to offset 0x0C clears each mask bit whose data bit is 1. Writing 0x7F clears the whole mask.
- R8: Reads return the status at 0x04 and the mask at 0x10. A read of 0x08, 0x0C or any other offset returns 0. A write to 0x10 changes nothing.
- R9: `irq_o` equals the OR over bits of (status AND mask) as they stood before the previous clock edge, so it lags the registers by one cycle.
- R10: Read data bits 31:7 are always 0. Write data bits 31:7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_i | input | 7 | Source inputs: levels on bits 4 and 2, pulses on the other bits |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench checks a clear write that lands on the same edge as a new pulse for that bit. A design that let the clear win would lose the event. It writes 0x7F to the status offset while both FIFO levels are high. A design that treated those bits as sticky would drop them to zero, or keep them set after the level falls. It writes patterns with mixed zeros and ones to both command registers, which catches a design that loads the mask instead of setting or clearing bits. A design that drives `irq_o` combinationally, or a cycle late, misses the exact-cycle comparison made on every clock.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned N_SRC  = 7;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h10;

  // bit 4: rx data present, bit 2: tx space free
  localparam logic [N_SRC-1:0] LEVEL_BITS = 7'b001_0100;

  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/spi_irq_regif.sv
module spi_irq_regif
  import spi_irq_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  src_vec_t          status_i,
  input  src_vec_t          mask_i,
  output src_vec_t          w1c_o,
  output src_vec_t          w1s_mask_o,
  output src_vec_t          w1c_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  src_vec_t wbits;
  logic     unused_wdata;

  assign wbits        = wdata_i[N_SRC-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:N_SRC];

  assign w1c_o      = (wr_en_i && addr_i == OFS_STATUS) ? wbits : '0;
  assign w1s_mask_o = (wr_en_i && addr_i == OFS_SET)    ? wbits : '0;
  assign w1c_mask_o = (wr_en_i && addr_i == OFS_CLR)    ? wbits : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_STATUS: rdata_o[N_SRC-1:0] = status_i;
      OFS_MASK:   rdata_o[N_SRC-1:0] = mask_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t src_i,
  input  src_vec_t w1c_i,
  output src_vec_t status_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (LEVEL_BITS[i]) begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_o[i] <= 1'b0;
        else         status_o[i] <= src_i[i];
      end
    end else begin : g_event
      // new event beats a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       status_o[i] <= 1'b0;
        else if (src_i[i]) status_o[i] <= 1'b1;
        else if (w1c_i[i]) status_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o
);
  src_vec_t status_q, mask_q, w1c, w1s_mask, w1c_mask;

  spi_irq_regif u_regif (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .status_i   (status_q),
    .mask_i     (mask_q),
    .w1c_o      (w1c),
    .w1s_mask_o (w1s_mask),
    .w1c_mask_o (w1c_mask),
    .rdata_o    (rdata_o)
  );

  spi_irq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .w1c_i    (w1c),
    .status_o (status_q)
  );

  spi_irq_mask u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (w1s_mask),
    .clr_i  (w1c_mask),
    .mask_o (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status_q & mask_q);
  end
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SRC-1:0]  src_i,
  input logic              irq_o,
  input src_vec_t          status_q,
  input src_vec_t          mask_q
);
  localparam src_vec_t EVT_BITS = ~LEVEL_BITS;

  // R2, R4: a pulse always leaves its bit set
  a_r2_event_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(src_i & EVT_BITS) |=> ((status_q & $past(src_i & EVT_BITS)) == $past(src_i & EVT_BITS)));

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_STATUS) |=>
      ((status_q & $past(wdata_i[N_SRC-1:0] & EVT_BITS & ~src_i)) == '0));

  a_r5_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & LEVEL_BITS) == $past(src_i & LEVEL_BITS)));

  a_r6_set_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_SET) |=>
      ((mask_q & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0])));

  a_r7_clr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CLR) |=> ((mask_q & $past(wdata_i[N_SRC-1:0])) == '0));

  a_r8_mask_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_MASK) |=> $stable(mask_q));

  a_r9_irq_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_q & mask_q))));
endmodule

bind spi_irq_unit spi_irq_chk u_chk (.*);

// File: tb/spi_irq_unit_test.sv
module spi_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [6:0]  src;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [6:0] m_st, m_mk;
  logic       m_irq;

  always #5 clk = ~clk;

  spi_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h04)      return {25'd0, m_st};
    else if (a == 8'h10) return {25'd0, m_mk};
    else                 return 32'd0;
  endfunction

  // compare at negedge, apply new inputs, then advance the model on the edge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [6:0] s);
    @(negedge clk);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    if (addr == 8'h04)      chk("R2 R3 R4 R5 status read", rdata, exp_read(addr));
    else if (addr == 8'h10) chk("R6 R7 R8 mask read", rdata, exp_read(addr));
    else                    chk("R8 R10 other read", rdata, exp_read(addr));
    wr_en = w; addr = a; wdata = d; src = s;
    @(posedge clk);
    m_irq = |(m_st & m_mk);
    for (int i = 0; i < 7; i++) begin
      if (i == 2 || i == 4) m_st[i] = s[i];
      else if (s[i])        m_st[i] = 1'b1;
      else if (w && a == 8'h04 && d[i]) m_st[i] = 1'b0;
    end
    if (w && a == 8'h08) m_mk = m_mk | d[6:0];
    if (w && a == 8'h0C) m_mk = m_mk & ~d[6:0];
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h04; wdata = '0; src = '0;
    m_st = '0; m_mk = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset status", rdata, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    addr = 8'h10;
    @(negedge clk);
    chk("R1 reset mask", rdata, 32'd0);

    // R2 event latch, enable mask, irq
    cyc(0, 8'h04, 0, 7'h01);
    cyc(0, 8'h04, 0, 7'h00);
    cyc(1, 8'h08, 32'hFFFF_FF01, 7'h00); // R10 upper bits ignored
    cyc(0, 8'h10, 0, 7'h00);
    cyc(0, 8'h04, 0, 7'h00);
    cyc(0, 8'h04, 0, 7'h00);
    @(negedge clk);
    chk("R2 latched bit0", rdata, 32'h01);
    chk("R9 irq asserted", {31'd0, irq}, 32'd1);

    // R3 W1C with zero bits no effect
    cyc(0, 8'h04, 0, 7'h48);
    cyc(1, 8'h04, 32'h0000_0008, 7'h00);
    cyc(0, 8'h04, 0, 7'h00);
    @(negedge clk);
    chk("R3 selective clear", rdata, 32'h41);

    // R4 clear and event same edge
    cyc(1, 8'h04, 32'h0000_0041, 7'h40);
    cyc(0, 8'h04, 0, 7'h00);
    @(negedge clk);
    chk("R4 event wins", rdata, 32'h40);

    // R5 levels ignore W1C and follow source
    cyc(0, 8'h04, 0, 7'h14);
    cyc(1, 8'h04, 32'h7F, 7'h14);
    cyc(0, 8'h04, 0, 7'h14);
    @(negedge clk);
    chk("R5 levels kept", rdata, 32'h14);
    cyc(0, 8'h04, 0, 7'h04);
    cyc(0, 8'h04, 0, 7'h00);
    @(negedge clk);
    chk("R5 levels follow", rdata, 32'h00);

    // R6, R7 set/clear with mixed patterns, R8 mask write ignored
    cyc(1, 8'h08, 32'h0000_0055, 7'h00);
    cyc(1, 8'h08, 32'h0000_0000, 7'h00);
    cyc(1, 8'h0C, 32'h0000_0011, 7'h00);
    cyc(1, 8'h10, 32'h0000_007F, 7'h00);
    cyc(0, 8'h10, 0, 7'h00);
    @(negedge clk);
    chk("R6 R7 R8 mask value", rdata, 32'h44);
    cyc(0, 8'h08, 0, 7'h00);
    cyc(0, 8'h0C, 0, 7'h00);
    cyc(0, 8'h20, 0, 7'h00);

    // R9 irq via level source and mask on bit 4
    cyc(1, 8'h08, 32'h10, 7'h10);
    cyc(0, 8'h04, 0, 7'h10);
    cyc(0, 8'h04, 0, 7'h00);
    cyc(1, 8'h0C, 32'h7F, 7'h00);
    cyc(0, 8'h10, 0, 7'h00);
    cyc(0, 8'h10, 0, 7'h00);
    @(negedge clk);
    chk("R7 full clear", rdata, 32'h00);
    chk("R9 irq off", {31'd0, irq}, 32'd0);

    // mixed traffic
    for (int k = 0; k < 200; k++) begin
      logic [7:0] a;
      case (k % 5)
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h0C; 3: a = 8'h10; default: a = 8'h18;
      endcase
      cyc(((k * 7) % 3) == 0, a, 32'(k * 37 + 5), 7'((k * 53) ^ (k >> 2)) & ((k % 4 == 0) ? 7'h7F : 7'h14));
    end
    cyc(0, 8'h04, 0, 7'h00);
    cyc(0, 8'h04, 0, 7'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule